// File: doc/BRIEF.md
# DMA Transfer Submission Register File

This block is the software-facing front end of a single-channel DMA engine. Software fills a set of staging registers (source and destination addresses, row length, row count, strides and mode flags), then commits them with a write to a start register. Each committed descriptor takes a 5-bit tag from a rolling counter and enters a four-slot queue. The datapath drains the queue through a valid/ready handshake and later reports each finished tag on a completion input.

Completion is recorded in a bitmask that software clears by writing ones. Two interrupt events are tracked in a pending register, gated by a mask, and ORed onto one interrupt line. One event fires when the datapath takes a queue slot and the other when a transfer finishes. Register bits with no storage read back as zero. Software can therefore probe the build: it learns the maximum length, the length alignment and whether scatter-gather exists by writing a pattern and reading it back.

Top module: `dma_submit_regs`

## Requirements
- R1: After reset, all of these read 0 and `irq_o` is low: control (0x400), next tag (0x404), start (0x408), pending (0x84) and done (0x428).
- R2: Writing 0xFFFFFFFF to row length (0x418) reads back 0x00FFFFFF, the maximum length. Writing 0 reads back 0x3, the alignment mask. Addresses (0x410 destination, 0x414 source) and strides (0x420 destination, 0x424 source) read back with bits [1:0] cleared. Row count (0x41C) keeps 16 bits and flags (0x40C) keep bits [2:0]. In control, the scatter-gather bit 2 always reads 0.
- R3: A write to start (0x408) with bit 0 set pushes the staged registers as one descriptor when control bit 0 (enable) is 1 and the queue is not full. The descriptor carries the tag that 0x404 showed just before the write, and the tag then advances modulo 32.
- R4: A start write is dropped when enable is 0 or when all 4 queue slots are full. The start register reads 1 exactly when 4 slots are occupied, and 0 otherwise.
- R5: The queue presents descriptors in commit order. `desc_valid_o` is high only while the queue is non-empty, enable is 1 and control bit 1 (pause) is 0. The descriptor is held stable until `desc_ready_i` accepts it.
- R6: Pending (0x84) bit 0 sets when the datapath accepts a descriptor, and bit 1 sets on each completion pulse, whatever the mask. Writing a 1 to a bit clears it, and a new event in the same cycle wins over the clear.
- R7: `irq_o` is the OR of pending AND mask (0x80, bits [1:0]). Register 0x88 reads pending AND mask.
- R8: Done (0x428) bit n sets when tag n completes, for n from 0 to 30, and clears when software writes a 1 to it. A completion in the same cycle wins over the clear. Bit 31 always reads 0 (no partial reports), so a completion of tag 31 raises only the end-of-transfer event.
- R9: Writing control with bit 0 clear empties the queue: start reads 0 and `desc_valid_o` falls. The next tag is kept.
- R10: Register 0x42C reads the tag of the descriptor most recently accepted by the datapath.
- R11: Offsets with no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| desc_valid_o | output | 1 | Queue head descriptor is offered |
| desc_ready_i | input | 1 | Datapath takes the head descriptor |
| desc_id_o | output | 5 | Tag of the head descriptor |
| desc_flags_o | output | 3 | Cyclic, last and partial-report flags |
| desc_dst_o | output | 32 | Destination address |
| desc_src_o | output | 32 | Source address |
| desc_xlen_o | output | 24 | Row length minus one |
| desc_ylen_o | output | 16 | Row count minus one |
| desc_dst_stride_o | output | 32 | Destination stride |
| desc_src_stride_o | output | 32 | Source stride |
| done_valid_i | input | 1 | Completion pulse from datapath |
| done_id_i | input | 5 | Tag that completed |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the datapath behaves:
- It raises `done_valid_i` for one cycle per completion.
- It only takes a descriptor through the handshake, never by reading the outputs alone.
- It never holds `desc_ready_i` against a register write that drops `desc_valid_o`.

The stimulus drives each input for one full cycle between falling edges. It asserts ready only inside a single accept step, after checking that a descriptor is offered. It reports completions one tag at a time, apart from one case where a completion and a clear of the same bit land in the same cycle on purpose.

// File: rtl/dma_submit_pkg.sv
package dma_submit_pkg;
  localparam logic [11:0] OFF_IRQ_MASK = 12'h080;
  localparam logic [11:0] OFF_IRQ_PEND = 12'h084;
  localparam logic [11:0] OFF_IRQ_SRC  = 12'h088;
  localparam logic [11:0] OFF_CTRL     = 12'h400;
  localparam logic [11:0] OFF_NEXT_ID  = 12'h404;
  localparam logic [11:0] OFF_START    = 12'h408;
  localparam logic [11:0] OFF_FLAGS    = 12'h40C;
  localparam logic [11:0] OFF_DST      = 12'h410;
  localparam logic [11:0] OFF_SRC      = 12'h414;
  localparam logic [11:0] OFF_XLEN     = 12'h418;
  localparam logic [11:0] OFF_YLEN     = 12'h41C;
  localparam logic [11:0] OFF_DSTRIDE  = 12'h420;
  localparam logic [11:0] OFF_SSTRIDE  = 12'h424;
  localparam logic [11:0] OFF_DONE     = 12'h428;
  localparam logic [11:0] OFF_ACT_ID   = 12'h42C;
  localparam int CTRL_EN    = 0;
  localparam int CTRL_PAUSE = 1;
  localparam int IRQ_SOT = 0;
  localparam int IRQ_EOT = 1;
  localparam int IRQ_N   = 2;
endpackage

// File: rtl/dma_desc_fifo.sv
module dma_desc_fifo #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && !flush_i && wr_q == PTR_W'(s)) mem_q[s] <= data_i;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_count_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] pending_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o <= '0;
      mask_o    <= '0;
    end else begin
      // new events win over a same-cycle clear
      pending_o <= (pending_o & ~(clr_we_i ? clr_i : '0)) | set_i;
      if (mask_we_i) mask_o <= mask_i;
    end
  end

  assign irq_o = |(pending_o & mask_o);

  assert_pend_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pending_o & $past(set_i)) == $past(set_i)));
  assert_irq_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o == '0) |-> !irq_o);
endmodule

// File: rtl/dma_done_tracker.sv
module dma_done_tracker #(
  parameter int ID_W  = 5,
  parameter int VIS_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_valid_i,
  input  logic [ID_W-1:0]  set_id_i,
  input  logic             clr_we_i,
  input  logic [VIS_W-1:0] clr_i,
  output logic [VIS_W-1:0] done_o
);
  for (genvar b = 0; b < VIS_W; b++) begin : g_bit
    logic hit;
    assign hit = set_valid_i && (set_id_i == ID_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 done_o[b] <= 1'b0;
      else if (hit)                done_o[b] <= 1'b1;
      else if (clr_we_i && clr_i[b]) done_o[b] <= 1'b0;
    end
  end

  assert_done_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_valid_i && (32'(set_id_i) < VIS_W)) |=> done_o[$past(set_id_i)]);
endmodule

// File: rtl/dma_submit_regs.sv
module dma_submit_regs
  import dma_submit_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 24,
  parameter int YLEN_W  = 16,
  parameter int ALIGN_W = 2,
  parameter int ID_W    = 5,
  parameter int DEPTH   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [11:0]       reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              desc_valid_o,
  input  logic              desc_ready_i,
  output logic [ID_W-1:0]   desc_id_o,
  output logic [2:0]        desc_flags_o,
  output logic [ADDR_W-1:0] desc_dst_o,
  output logic [ADDR_W-1:0] desc_src_o,
  output logic [LEN_W-1:0]  desc_xlen_o,
  output logic [YLEN_W-1:0] desc_ylen_o,
  output logic [ADDR_W-1:0] desc_dst_stride_o,
  output logic [ADDR_W-1:0] desc_src_stride_o,
  input  logic              done_valid_i,
  input  logic [ID_W-1:0]   done_id_i,
  output logic              irq_o
);
  localparam int NUM_IDS = 1 << ID_W;
  localparam int VIS_W   = (NUM_IDS < 31) ? NUM_IDS : 31;
  localparam int DATA_W  = ID_W + 3 + 4 * ADDR_W + LEN_W + YLEN_W;
  localparam logic [ADDR_W-1:0] ADDR_KEEP = {ADDR_W{1'b1}} << ALIGN_W;
  localparam logic [LEN_W-1:0]  LEN_LOW   = LEN_W'((1 << ALIGN_W) - 1);

  logic [1:0]        ctrl_q;
  logic [2:0]        flags_q;
  logic [ADDR_W-1:0] dst_q, src_q, dstr_q, sstr_q;
  logic [LEN_W-1:0]  xlen_q;
  logic [YLEN_W-1:0] ylen_q;
  logic [ID_W-1:0]   next_id_q, act_id_q;

  logic wr_ctrl, push, pop, flush, q_empty, q_full;
  logic [DATA_W-1:0] q_in, q_out;
  logic [IRQ_N-1:0]  pend, mask;
  logic [VIS_W-1:0]  done_bits;

  assign wr_ctrl = reg_we_i && reg_addr_i == OFF_CTRL;
  assign flush   = wr_ctrl && !reg_wdata_i[CTRL_EN];
  assign push    = reg_we_i && reg_addr_i == OFF_START && reg_wdata_i[0]
                   && ctrl_q[CTRL_EN] && !q_full;
  assign desc_valid_o = !q_empty && ctrl_q[CTRL_EN] && !ctrl_q[CTRL_PAUSE];
  assign pop     = desc_valid_o && desc_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      flags_q   <= '0;
      dst_q     <= '0;
      src_q     <= '0;
      dstr_q    <= '0;
      sstr_q    <= '0;
      xlen_q    <= LEN_LOW;
      ylen_q    <= '0;
      next_id_q <= '0;
      act_id_q  <= '0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_i)
          OFF_CTRL:    ctrl_q  <= reg_wdata_i[1:0];
          OFF_FLAGS:   flags_q <= reg_wdata_i[2:0];
          OFF_DST:     dst_q   <= reg_wdata_i[ADDR_W-1:0] & ADDR_KEEP;
          OFF_SRC:     src_q   <= reg_wdata_i[ADDR_W-1:0] & ADDR_KEEP;
          OFF_DSTRIDE: dstr_q  <= reg_wdata_i[ADDR_W-1:0] & ADDR_KEEP;
          OFF_SSTRIDE: sstr_q  <= reg_wdata_i[ADDR_W-1:0] & ADDR_KEEP;
          OFF_XLEN:    xlen_q  <= reg_wdata_i[LEN_W-1:0] | LEN_LOW;
          OFF_YLEN:    ylen_q  <= reg_wdata_i[YLEN_W-1:0];
          default: ;
        endcase
      end
      if (push) next_id_q <= next_id_q + 1'b1;
      if (pop)  act_id_q  <= desc_id_o;
    end
  end

  assign q_in = {next_id_q, flags_q, dst_q, src_q, xlen_q, ylen_q, dstr_q, sstr_q};
  assign {desc_id_o, desc_flags_o, desc_dst_o, desc_src_o, desc_xlen_o,
          desc_ylen_o, desc_dst_stride_o, desc_src_stride_o} = q_out;

  dma_desc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(push), .data_i(q_in),
    .pop_i(pop), .data_o(q_out), .empty_o(q_empty), .full_o(q_full)
  );

  dma_irq_ctrl #(.N(IRQ_N)) u_irq (
    .clk_i, .rst_ni,
    .set_i({done_valid_i, pop}),
    .clr_we_i(reg_we_i && reg_addr_i == OFF_IRQ_PEND),
    .clr_i(reg_wdata_i[IRQ_N-1:0]),
    .mask_we_i(reg_we_i && reg_addr_i == OFF_IRQ_MASK),
    .mask_i(reg_wdata_i[IRQ_N-1:0]),
    .pending_o(pend), .mask_o(mask), .irq_o(irq_o)
  );

  dma_done_tracker #(.ID_W(ID_W), .VIS_W(VIS_W)) u_done (
    .clk_i, .rst_ni, .set_valid_i(done_valid_i), .set_id_i(done_id_i),
    .clr_we_i(reg_we_i && reg_addr_i == OFF_DONE),
    .clr_i(reg_wdata_i[VIS_W-1:0]), .done_o(done_bits)
  );

  always_comb begin
    case (reg_addr_i)
      OFF_IRQ_MASK: reg_rdata_o = 32'(mask);
      OFF_IRQ_PEND: reg_rdata_o = 32'(pend);
      OFF_IRQ_SRC:  reg_rdata_o = 32'(pend & mask);
      OFF_CTRL:     reg_rdata_o = 32'(ctrl_q);
      OFF_NEXT_ID:  reg_rdata_o = 32'(next_id_q);
      OFF_START:    reg_rdata_o = 32'(q_full);
      OFF_FLAGS:    reg_rdata_o = 32'(flags_q);
      OFF_DST:      reg_rdata_o = 32'(dst_q);
      OFF_SRC:      reg_rdata_o = 32'(src_q);
      OFF_XLEN:     reg_rdata_o = 32'(xlen_q);
      OFF_YLEN:     reg_rdata_o = 32'(ylen_q);
      OFF_DSTRIDE:  reg_rdata_o = 32'(dstr_q);
      OFF_SSTRIDE:  reg_rdata_o = 32'(sstr_q);
      OFF_DONE:     reg_rdata_o = 32'(done_bits);
      OFF_ACT_ID:   reg_rdata_o = 32'(act_id_q);
      default:      reg_rdata_o = '0;
    endcase
  end

  assert_id_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> next_id_q == ID_W'($past(next_id_q) + 1'b1));
  assert_desc_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && !desc_ready_i && !reg_we_i) |=> (desc_valid_o && $stable(desc_id_o)));
  assert_flush_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> !desc_valid_o);
  assert_act_id_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> act_id_q == $past(desc_id_o));
endmodule

// File: tb/dma_submit_regs_bench.sv
`timescale 1ns/1ps
module dma_submit_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dvalid, dready = 1'b0;
  logic [4:0]  did;
  logic [2:0]  dflags;
  logic [31:0] ddst, dsrc, ddstr, dsstr;
  logic [23:0] dxlen;
  logic [15:0] dylen;
  logic        cvalid = 1'b0;
  logic [4:0]  cid = '0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  dma_submit_regs u_dma_submit_regs (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .desc_valid_o(dvalid),
    .desc_ready_i(dready), .desc_id_o(did), .desc_flags_o(dflags),
    .desc_dst_o(ddst), .desc_src_o(dsrc), .desc_xlen_o(dxlen),
    .desc_ylen_o(dylen), .desc_dst_stride_o(ddstr), .desc_src_stride_o(dsstr),
    .done_valid_i(cvalid), .done_id_i(cid), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic accept(input string tag, input logic [4:0] exp_id);
    @(negedge clk); dready = 1'b1; #1;
    chk({tag, " valid"}, 32'(dvalid), 32'd1);
    chk({tag, " id"}, 32'(did), 32'(exp_id));
    @(negedge clk); dready = 1'b0;
  endtask

  task automatic complete(input logic [4:0] id);
    @(negedge clk); cvalid = 1'b1; cid = id;
    @(negedge clk); cvalid = 1'b0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 ctrl", 12'h400, 0);
    rd_chk("R1 next id", 12'h404, 0);
    rd_chk("R1 start", 12'h408, 0);
    rd_chk("R1 pending", 12'h084, 0);
    rd_chk("R1 done", 12'h428, 0);
    chk("R1 irq", 32'(irq), 0);

    // R11 holes
    rd_chk("R11 hole 0x000", 12'h000, 0);
    rd_chk("R11 hole 0x0FC", 12'h0FC, 0);
    rd_chk("R11 hole 0x500", 12'h500, 0);

    // R2 capability probing
    wr(12'h418, 32'hFFFF_FFFF); rd_chk("R2 xlen max", 12'h418, 32'h00FF_FFFF);
    wr(12'h418, 32'h0);         rd_chk("R2 xlen align", 12'h418, 32'h3);
    wr(12'h410, 32'hFFFF_FFFF); rd_chk("R2 dst", 12'h410, 32'hFFFF_FFFC);
    wr(12'h424, 32'hFFFF_FFFF); rd_chk("R2 sstride", 12'h424, 32'hFFFF_FFFC);
    wr(12'h41C, 32'hFFFF_FFFF); rd_chk("R2 ylen", 12'h41C, 32'h0000_FFFF);
    wr(12'h40C, 32'hFFFF_FFFF); rd_chk("R2 flags", 12'h40C, 32'h7);
    wr(12'h400, 32'h7);         rd_chk("R2 ctrl sg bit", 12'h400, 32'h3);
    wr(12'h400, 32'h0);

    // R4 start ignored while disabled
    wr(12'h408, 32'h1);
    rd_chk("R4 disabled next id", 12'h404, 0);
    chk("R4 disabled valid", 32'(dvalid), 0);

    // R3 fill the queue with distinct descriptors
    wr(12'h400, 32'h1);
    for (int i = 0; i < 4; i++) begin
      rd_chk("R3 next id before", 12'h404, 32'(i));
      wr(12'h410, 32'h1000_0000 + 32'(i) * 32'h100);
      wr(12'h414, 32'h2000_0000 + 32'(i) * 32'h40);
      wr(12'h418, 32'h40 * 32'(i) + 32'h3);
      wr(12'h41C, 32'(i + 1));
      wr(12'h40C, 32'(i));
      wr(12'h420, 32'h80 + 32'(i) * 4);
      wr(12'h408, 32'h1);
    end
    rd_chk("R4 start full", 12'h408, 1);
    wr(12'h408, 32'h1);
    rd_chk("R4 full next id", 12'h404, 4);

    // R5 pause holds the queue
    wr(12'h400, 32'h3);
    chk("R5 paused valid", 32'(dvalid), 0);
    wr(12'h400, 32'h1);

    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk("R5 dst", ddst, 32'h1000_0000 + 32'(i) * 32'h100);
      chk("R5 src", dsrc, 32'h2000_0000 + 32'(i) * 32'h40);
      chk("R5 xlen", 32'(dxlen), 32'h40 * 32'(i) + 32'h3);
      chk("R5 ylen", 32'(dylen), 32'(i + 1));
      chk("R5 flags", 32'(dflags), 32'(i));
      chk("R5 dstride", ddstr, 32'h80 + 32'(i) * 4);
      accept("R5 order", 5'(i));
      rd_chk("R10 active id", 12'h42C, 32'(i));
      rd_chk("R6 sot pending", 12'h084, 1);
      if (i == 0) rd_chk("R4 start after pop", 12'h408, 0);
    end
    chk("R5 empty valid", 32'(dvalid), 0);
    wr(12'h084, 32'h3);
    rd_chk("R6 w1c", 12'h084, 0);

    // R6/R7 masking
    wr(12'h428, 32'hFFFF_FFFF);
    complete(5'd2);
    rd_chk("R6 eot unmasked", 12'h084, 2);
    chk("R7 irq masked", 32'(irq), 0);
    rd_chk("R7 source masked", 12'h088, 0);
    wr(12'h080, 32'h2);
    chk("R7 irq on", 32'(irq), 1);
    rd_chk("R7 source", 12'h088, 2);
    wr(12'h084, 32'h2);
    chk("R7 irq off", 32'(irq), 0);
    wr(12'h080, 32'h0);

    // R8 sweep of every tag
    wr(12'h428, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      complete(5'(n));
      rd_chk("R8 done set", 12'h428, (n < 31) ? (32'h1 << n) : 32'h0);
      wr(12'h428, 32'hFFFF_FFFF);
      rd_chk("R8 done clr", 12'h428, 0);
    end
    // R8 set beats clear in the same cycle
    @(negedge clk); cvalid = 1'b1; cid = 5'd7; we = 1'b1; addr = 12'h428; wdata = 32'h80;
    @(negedge clk); cvalid = 1'b0; we = 1'b0;
    rd_chk("R8 set wins", 12'h428, 32'h80);
    // R6 set beats clear in the same cycle
    wr(12'h084, 32'h3);
    @(negedge clk); cvalid = 1'b1; cid = 5'd1; we = 1'b1; addr = 12'h084; wdata = 32'h2;
    @(negedge clk); cvalid = 1'b0; we = 1'b0;
    rd_chk("R6 set wins", 12'h084, 2);

    // R3 tag wrap modulo 32
    for (int k = 4; k < 32; k++) begin
      wr(12'h408, 32'h1);
      accept("R3 tag", 5'(k));
    end
    rd_chk("R3 wrap", 12'h404, 0);

    // R9 flush
    for (int i = 0; i < 4; i++) wr(12'h408, 32'h1);
    rd_chk("R9 full before", 12'h408, 1);
    wr(12'h400, 32'h0);
    rd_chk("R9 start after flush", 12'h408, 0);
    chk("R9 valid after flush", 32'(dvalid), 0);
    rd_chk("R9 next id kept", 12'h404, 4);
    wr(12'h400, 32'h1);
    chk("R9 empty after enable", 32'(dvalid), 0);

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule